// File: doc/BRIEF.md
# Multi-Port Handshake Dock Controller

The controller sits between a processing unit and a group of request/acknowledge ports. Each input lane carries a data word plus one extra top bit. When that bit is set, the word is a flush token. A flush token is kept out of sight of the unit: the request the unit sees is masked. The token waits until every input lane holds a flush token in the same cycle. At that point all of the tokens are acknowledged together through a per-lane flush flag that is ORed into the outgoing acknowledge.

For every port, the controller also handles the rest of the handshake. It sets the reset state, performs cleanup after each transfer, and reports full, empty and draining conditions. The unit itself is not part of this block. A simple merge stands in for it: input lane i feeds output (i mod NUM_OUT), and the lowest-numbered lane with a waiting word wins.

All ports follow a four-phase handshake. A producer raises its request and waits for acknowledge, then lowers its request. A consumer raises acknowledge when it has the word and lowers it once the request has fallen.

Top module: `dock_ctrl`

## Requirements
- R1: While the synchronous active-high reset is asserted, every input acknowledge is high and every output request is low.
- R2: Bit DATA_W (the top bit) of each input lane marks a flush token. A marked word is never forwarded to an output, and it never makes its lane report full.
- R3: A non-flush word on a lane whose output port is empty (request and acknowledge both low) is taken at the next clock edge. At that edge the output request rises, the output data carries the low DATA_W bits of the lane, and the lane acknowledge rises. Words leave in the order they were accepted.
- R4: An unmarked word waits, with its acknowledge held low, for as long as its output port is not empty.
- R5: An input acknowledge that is high while the lane's request is low falls at the next clock edge.
- R6: An output request with acknowledge high falls at the next edge. While the request is high and acknowledge is low, the request and the data are held unchanged.
- R7: In a cycle where every input lane has its request high, its acknowledge low and its flush bit set, every input acknowledge is high after the next edge. Each stays high until its lane's request falls.
- R8: A flush token on some lanes while other lanes hold no flush token is not acknowledged.
- R9: Status outputs are defined as follows. An input is full when an unmarked request is waiting with internal acknowledge low. An input is empty when neither a visible request nor internal acknowledge is present. An output is full when request is high and acknowledge is low, empty when both are low, and draining when both are high.
- R10: Lanes other than the first are merged into output 0 by the default configuration. When lane 0 and lane 1 both hold words in the same cycle, lane 0 is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | NUM_IN | Raw request per input lane |
| in_data | input | NUM_IN*(DATA_W+1) | Lane words, lane i at [i*(DATA_W+1) +: DATA_W+1], top bit = flush mark |
| in_ack | output | NUM_IN | Acknowledge per input lane (internal ack OR flush flag) |
| in_full | output | NUM_IN | Input lane holds a visible word not yet taken |
| in_empty | output | NUM_IN | Input lane has no visible request and no internal ack |
| out_req | output | NUM_OUT | Request per output port |
| out_data | output | NUM_OUT*DATA_W | Output words, port j at [j*DATA_W +: DATA_W] |
| out_ack | input | NUM_OUT | Acknowledge from each output consumer |
| out_full | output | NUM_OUT | Output request high, acknowledge low |
| out_empty | output | NUM_OUT | Output request and acknowledge both low |
| out_draining | output | NUM_OUT | Output request and acknowledge both high |

## Verification
The hardest state to reach is a partial flush: one lane holds a flush token while the other lane is idle. In that state the lane must stay unacknowledged, and it must also stay invisible as a full word. The stimulus parks a marked word on lane 0 for several cycles and then brings a marked word onto lane 1, which releases both lanes in one edge. Output back-pressure is reached by turning the consumer off while a second word is presented, and the lane-priority merge is reached by starting two producers on the same clock.

// File: rtl/dock_pkg.sv
package dock_pkg;

    typedef struct packed {
        logic full;
        logic empty;
        logic flush_cand;
    } in_stat_t;

    typedef struct packed {
        logic full;
        logic empty;
        logic draining;
    } out_stat_t;

    function automatic in_stat_t in_status(input logic raw_req, input logic mark,
                                           input logic ack);
        in_stat_t s;
        logic     vis;
        vis          = raw_req & ~mark;
        s.full       = vis & ~ack;
        s.empty      = ~vis & ~ack;
        s.flush_cand = raw_req & mark & ~ack;
        return s;
    endfunction

    function automatic out_stat_t out_status(input logic req, input logic ack);
        out_stat_t s;
        s.full     = req & ~ack;
        s.empty    = ~req & ~ack;
        s.draining = req & ack;
        return s;
    endfunction

endpackage

// File: rtl/dock_in_port.sv
module dock_in_port
    import dock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     raw_req,
    input  logic     mark,
    input  logic     take,
    input  logic     flush_all,
    output logic     ack_o,
    output in_stat_t stat_o
);
    logic ack_q;
    logic flush_q;
    logic vis_req;

    assign vis_req = raw_req & ~mark;
    assign stat_o  = in_status(raw_req, mark, ack_q);
    assign ack_o   = ack_q | flush_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b1;
            flush_q <= 1'b0;
        end else begin
            if (take)
                ack_q <= 1'b1;
            else if (!vis_req && ack_q)
                ack_q <= 1'b0;

            if (!raw_req)
                flush_q <= 1'b0;
            else if (flush_all)
                flush_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dock_out_port.sv
module dock_out_port
    import dock_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              ack_in,
    output logic              req_o,
    output logic [DATA_W-1:0] data_o,
    output out_stat_t         stat_o
);
    logic              req_q;
    logic [DATA_W-1:0] data_q;

    assign req_o  = req_q;
    assign data_o = data_q;
    assign stat_o = out_status(req_q, ack_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            data_q <= '0;
        end else if (load) begin
            req_q  <= 1'b1;
            data_q <= load_data;
        end else if (req_q && ack_in) begin
            req_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dock_ctrl.sv
module dock_ctrl
    import dock_pkg::*;
#(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 1,
    parameter int DATA_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_IN-1:0]           in_req,
    input  logic [NUM_IN*(DATA_W+1)-1:0] in_data,
    output logic [NUM_IN-1:0]           in_ack,
    output logic [NUM_IN-1:0]           in_full,
    output logic [NUM_IN-1:0]           in_empty,
    output logic [NUM_OUT-1:0]          out_req,
    output logic [NUM_OUT*DATA_W-1:0]   out_data,
    input  logic [NUM_OUT-1:0]          out_ack,
    output logic [NUM_OUT-1:0]          out_full,
    output logic [NUM_OUT-1:0]          out_empty,
    output logic [NUM_OUT-1:0]          out_draining
);
    localparam int LANE_W = DATA_W + 1;

    in_stat_t          in_st   [NUM_IN];
    out_stat_t         out_st  [NUM_OUT];
    logic [NUM_IN-1:0] in_mark;
    logic [NUM_IN-1:0] cand;
    logic [NUM_IN-1:0] take;
    logic              flush_all;
    logic [NUM_OUT-1:0] load;
    logic [DATA_W-1:0] load_word [NUM_OUT];

    assign flush_all = &cand;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        assign in_mark[i]  = in_data[i*LANE_W + DATA_W];
        assign cand[i]     = in_st[i].flush_cand;
        assign in_full[i]  = in_st[i].full;
        assign in_empty[i] = in_st[i].empty;

        dock_in_port u_port (
            .clk       (clk),
            .rst       (rst),
            .raw_req   (in_req[i]),
            .mark      (in_mark[i]),
            .take      (take[i]),
            .flush_all (flush_all),
            .ack_o     (in_ack[i]),
            .stat_o    (in_st[i])
        );
    end

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        assign out_full[j]     = out_st[j].full;
        assign out_empty[j]    = out_st[j].empty;
        assign out_draining[j] = out_st[j].draining;

        dock_out_port #(.DATA_W(DATA_W)) u_port (
            .clk       (clk),
            .rst       (rst),
            .load      (load[j]),
            .load_data (load_word[j]),
            .ack_in    (out_ack[j]),
            .req_o     (out_req[j]),
            .data_o    (out_data[j*DATA_W +: DATA_W]),
            .stat_o    (out_st[j])
        );
    end

    // Stand-in unit: lane i feeds output (i mod NUM_OUT), lowest lane first.
    always_comb begin
        take = '0;
        load = '0;
        for (int j = 0; j < NUM_OUT; j++) begin
            load_word[j] = '0;
            for (int i = 0; i < NUM_IN; i++) begin
                if ((i % NUM_OUT) == j && in_st[i].full && out_st[j].empty && !load[j]) begin
                    take[i]      = 1'b1;
                    load[j]      = 1'b1;
                    load_word[j] = in_data[i*LANE_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/dock_ctrl_chk.sv
module dock_ctrl_chk #(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 1,
    parameter int DATA_W  = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_IN-1:0]         in_req,
    input logic [NUM_IN-1:0]         in_mark,
    input logic [NUM_IN-1:0]         in_ack,
    input logic [NUM_OUT-1:0]        out_req,
    input logic [NUM_OUT*DATA_W-1:0] out_data,
    input logic [NUM_OUT-1:0]        out_ack
);
    logic [NUM_IN-1:0] waiting_tok;
    logic [NUM_IN-1:0] held_tok;
    logic [NUM_IN-1:0] visible;

    assign waiting_tok = in_req & in_mark & ~in_ack;
    assign held_tok    = in_req & in_mark & in_ack;
    assign visible     = in_req & ~in_mark & ~in_ack;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ack == '1 && out_req == '0));

    assert_fwd_visible_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_req[0]) |-> $past(|visible));

    assert_group_flush_R7: assert property (@(posedge clk) disable iff (rst)
        (&waiting_tok) |=> (&in_ack));

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in_chk
        assert_in_cleanup_R5: assert property (@(posedge clk) disable iff (rst)
            (in_ack[i] && !in_req[i]) |=> !in_ack[i]);

        assert_no_partial_flush_R8: assert property (@(posedge clk) disable iff (rst)
            (waiting_tok[i] && !(&waiting_tok) && held_tok == '0) |=> !in_ack[i]);
    end

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out_chk
        assert_out_cleanup_R6: assert property (@(posedge clk) disable iff (rst)
            (out_req[j] && out_ack[j]) |=> !out_req[j]);

        assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (out_req[j] && !out_ack[j]) |=>
                (out_req[j] && $stable(out_data[j*DATA_W +: DATA_W])));
    end
endmodule

bind dock_ctrl dock_ctrl_chk #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_req   (in_req),
    .in_mark  (in_mark),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_data (out_data),
    .out_ack  (out_ack)
);

// File: tb/sim_dock_ctrl.sv
`timescale 1ns/100ps
module sim_dock_ctrl;
    localparam int NI = 2;
    localparam int NO = 1;
    localparam int W  = 32;
    localparam int LW = W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [NI-1:0]    in_req  = '0;
    logic [NI*LW-1:0] in_data = '0;
    logic [NO-1:0]    out_ack = '0;
    logic [NI-1:0]    in_ack, in_full, in_empty;
    logic [NO-1:0]    out_req, out_full, out_empty, out_draining;
    logic [NO*W-1:0]  out_data;

    dock_ctrl #(.NUM_IN(NI), .NUM_OUT(NO), .DATA_W(W)) u0 (
        .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .in_full(in_full), .in_empty(in_empty),
        .out_req(out_req), .out_data(out_data), .out_ack(out_ack),
        .out_full(out_full), .out_empty(out_empty), .out_draining(out_draining)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cons_en = 1'b0;
    int cons_dly = 0;
    logic [W-1:0] exp_q [$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Behavioural reference of the handshake, default configuration.
    logic [NI-1:0] m_ack, m_fl;
    logic          m_oreq;
    logic [W-1:0]  m_odata;

    always @(posedge clk) begin
        logic          all_tok, granted, oe, vis;
        logic [NI-1:0] n_ack, n_fl;
        logic          n_oreq;
        logic [W-1:0]  n_odata;
        cyc++;
        if (rst) begin
            m_ack   <= '1;
            m_fl    <= '0;
            m_oreq  <= 1'b0;
            m_odata <= '0;
        end else begin
            all_tok = 1'b1;
            for (int i = 0; i < NI; i++)
                if (!(in_req[i] && in_data[i*LW+W] && !m_ack[i])) all_tok = 1'b0;
            n_oreq  = m_oreq;
            n_odata = m_odata;
            oe      = !m_oreq && !out_ack[0];
            if (m_oreq && out_ack[0]) n_oreq = 1'b0;
            granted = 1'b0;
            for (int i = 0; i < NI; i++) begin
                vis      = in_req[i] && !in_data[i*LW+W];
                n_ack[i] = m_ack[i];
                if (vis && !m_ack[i] && oe && !granted) begin
                    granted  = 1'b1;
                    n_ack[i] = 1'b1;
                    n_oreq   = 1'b1;
                    n_odata  = in_data[i*LW +: W];
                end else if (!vis && m_ack[i]) begin
                    n_ack[i] = 1'b0;
                end
                n_fl[i] = m_fl[i];
                if (!in_req[i]) n_fl[i] = 1'b0;
                else if (all_tok) n_fl[i] = 1'b1;
            end
            m_ack   <= n_ack;
            m_fl    <= n_fl;
            m_oreq  <= n_oreq;
            m_odata <= n_odata;
        end
    end

    always @(posedge clk) begin
        #1;
        if (cyc >= 2) begin
            chk("R5 in_ack vs model", 64'(in_ack), 64'(m_ack | m_fl));
            chk("R6 out_req vs model", 64'(out_req[0]), 64'(m_oreq));
            if (m_oreq) chk("R3 out_data vs model", 64'(out_data[W-1:0]), 64'(m_odata));
        end
    end

    // Consumer on output 0
    initial forever begin
        @(negedge clk);
        if (cons_en) begin
            if (out_req[0] && !out_ack[0]) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected output word", 64'(out_data[W-1:0]), 64'hDEAD);
                end else begin
                    chk("R3 output order", 64'(out_data[W-1:0]), 64'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
                repeat (cons_dly) @(negedge clk);
                out_ack[0] = 1'b1;
            end else if (out_ack[0] && !out_req[0]) begin
                out_ack[0] = 1'b0;
            end
        end
    end

    task automatic send(input int p, input logic [W-1:0] d, input bit mark, input bit push);
        if (push) exp_q.push_back(d);
        @(negedge clk);
        in_data[p*LW +: LW] = {mark, d};
        in_req[p] = 1'b1;
        do @(negedge clk); while (!in_ack[p]);
        in_req[p] = 1'b0;
        do @(negedge clk); while (in_ack[p]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in_ack during reset", 64'(in_ack), 64'(2'b11));
        chk("R1 out_req during reset", 64'(out_req), 64'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R5 ack drops after reset", 64'(in_ack), 64'd0);
        chk("R9 out empty idle", 64'(out_empty), 64'd1);

        // R3: forwarding, no consumer delay
        cons_en = 1'b1; cons_dly = 0;
        send(0, 32'h1111_0001, 1'b0, 1'b1);
        send(0, 32'h2222_0002, 1'b0, 1'b1);
        send(0, 32'h3333_0003, 1'b0, 1'b1);
        // slower consumer
        cons_dly = 3;
        send(0, 32'hA5A5_0004, 1'b0, 1'b1);
        send(0, 32'h5A5A_0005, 1'b0, 1'b1);
        repeat (8) @(posedge clk);

        // R4: back-pressure
        cons_en = 1'b0; cons_dly = 1;
        send(0, 32'hCAFE_0006, 1'b0, 1'b1);
        fork
            send(0, 32'hBEEF_0007, 1'b0, 1'b1);
            begin
                @(negedge clk); #1;
                repeat (4) begin
                    @(posedge clk); #1;
                    chk("R4 held ack low", 64'(in_ack[0]), 64'd0);
                    chk("R9 in_full", 64'(in_full[0]), 64'd1);
                    chk("R9 out_full", 64'(out_full[0]), 64'd1);
                    chk("R6 data held", 64'(out_data[W-1:0]), 64'hCAFE_0006);
                end
                @(negedge clk); cons_en = 1'b1;
            end
        join
        repeat (10) @(posedge clk);

        // R9: draining, manual consumer
        cons_en = 1'b0;
        send(0, 32'h0D0D_0008, 1'b0, 1'b0);
        @(negedge clk); out_ack[0] = 1'b1; #1;
        chk("R9 out_draining", 64'(out_draining[0]), 64'd1);
        chk("R3 drained word", 64'(out_data[W-1:0]), 64'h0D0D_0008);
        @(posedge clk); #1;
        chk("R6 req drops on ack", 64'(out_req[0]), 64'd0);
        chk("R9 not empty while ack", 64'(out_empty[0]), 64'd0);
        @(negedge clk); out_ack[0] = 1'b0; #1;
        chk("R9 out_empty", 64'(out_empty[0]), 64'd1);
        cons_en = 1'b1;

        // R8: partial flush, then R7 completion
        @(negedge clk);
        in_data[0*LW +: LW] = {1'b1, 32'h0F0F_0F0F};
        in_req[0] = 1'b1;
        repeat (4) begin
            @(posedge clk); #1;
            chk("R8 lone token not acked", 64'(in_ack[0]), 64'd0);
            chk("R2 token not full", 64'(in_full[0]), 64'd0);
            chk("R9 token lane empty", 64'(in_empty[0]), 64'd1);
            chk("R2 token not forwarded", 64'(out_req[0]), 64'd0);
        end
        @(negedge clk);
        in_data[1*LW +: LW] = {1'b1, 32'h1234_5678};
        in_req[1] = 1'b1;
        @(posedge clk); #1;
        chk("R7 all acked together", 64'(in_ack), 64'(2'b11));
        @(posedge clk); #1;
        chk("R7 ack held while req", 64'(in_ack), 64'(2'b11));
        chk("R2 no output after flush", 64'(out_req[0]), 64'd0);
        @(negedge clk); in_req = '0;
        @(posedge clk); #1;
        chk("R5 flush ack released", 64'(in_ack), 64'd0);

        // R7: simultaneous flush through producers
        fork
            send(0, 32'hFFFF_0000, 1'b1, 1'b0);
            send(1, 32'h0000_FFFF, 1'b1, 1'b0);
        join
        repeat (3) @(posedge clk); #1;
        chk("R2 flush never reaches output", 64'(out_req[0]), 64'd0);

        // R10: lane 1 merge and lane priority
        cons_dly = 2;
        send(1, 32'h7777_0009, 1'b0, 1'b1);
        exp_q.push_back(32'h8888_000A);
        exp_q.push_back(32'h9999_000B);
        fork
            send(0, 32'h8888_000A, 1'b0, 1'b0);
            send(1, 32'h9999_000B, 1'b0, 1'b0);
        join
        repeat (12) @(posedge clk); #1;
        chk("R10 all merged words delivered", 64'(exp_q.size()), 64'd0);
        chk("R6 output idle at end", 64'(out_req[0]), 64'd0);

        report();
        $finish;
    end
endmodule